// File: doc/BRIEF.md
# Strobed Parallel I/O Port with Service Request

This block is a byte-wide parallel port for a microprocessor bus, modelled in a single system-clock domain. It holds a data latch and a decode of two select inputs, one active-low and one active-high. A mode input picks what loads the latch. In output mode the select term loads it and the outputs are always driven. In input mode a peripheral strobe loads it, and the outputs are driven only while the port is selected. The high-impedance drive is brought out as a data bus plus an output-enable flag.

The latch behaves as a transparent latch. While its load term is high, the output passes the data input straight through, and each rising clock edge stores that input. While the load term is low, the output shows the stored byte. A service-request flip-flop is set by a falling edge of the strobe, which is found by comparing the strobe with its previous clock-edge sample. Selecting the port clears the flip-flop. The active-low interrupt output is low while a request is pending or while the port is selected. An active-low clear input empties the latch and the request. A high load term overrides the clear for the latch only.

The data path has no flow control. The data input is sampled as a level and the output is a level, so the port applies no back-pressure and has no valid/ready pair. The processor and peripheral keep data steady around the load term, as they would with a discrete latch.

Top module: `strobed_io_port`

## Requirements
- R1: The port counts as selected only when `sel_n` is 0 and `sel` is 1; the other three combinations leave it unselected.
- R2: With `mode` = 1 (output mode), `oe` is 1 whatever the select and strobe inputs are, and the latch load term equals the select term.
- R3: With `mode` = 0 (input mode), `oe` equals the select term, and the latch load term equals `strobe`.
- R4: While the load term is 1 and `oe` is 1, `dout` equals `din` in the same cycle.
- R5: While the load term is 0 and `clr_n` is 1, `dout` shows the `din` value sampled at the last rising clock edge at which the load term was 1, and the stored byte does not change.
- R6: `clr_n` = 0 with the load term at 0 forces `dout` to 0 at once, without a clock edge. The stored byte is 0 once a clock edge passes, so `dout` still reads 0 after `clr_n` returns to 1.
- R7: While `clr_n` is 0 and the load term is 1, `dout` follows `din` and a rising clock edge still stores `din`.
- R8: A rising clock edge at which `strobe` is 0, having been 1 at the previous edge, sets the service request when the port is not selected. `irq_n` then reads 0 from that edge on.
- R9: Any rising clock edge at which the port is selected clears the service request. This holds even when a strobe falling edge is seen at that same edge.
- R10: `clr_n` = 0 clears the service request and the strobe history at once, without a clock edge.
- R11: `irq_n` is 0 exactly when the request is pending or the port is selected, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all storage updates on its rising edge |
| clr_n | input | 1 | Active-low clear of latch and service request |
| sel_n | input | 1 | Active-low select input |
| sel | input | 1 | Active-high select input |
| mode | input | 1 | 1 = output mode, 0 = input mode |
| strobe | input | 1 | Peripheral strobe; latch load in input mode, request set on its fall |
| din | input | WIDTH (8) | Parallel data input |
| dout | output | WIDTH (8) | Parallel data output, meaningful while `oe` is 1 |
| oe | output | 1 | Output enable; 0 stands for high impedance |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The clocked properties assume that every input is steady at the rising clock edge and changes only between edges. The latch and request checks also assume that `clr_n` has been high since the previous edge, and apart from the clear checks they are switched off while `clr_n` is low. The bench changes every input on the falling clock edge and samples the outputs one time unit later. It holds `din` steady around each edge where the load term is high, so a stored byte is always a value the bench set on purpose. It sweeps all sixteen combinations of mode, strobe and the two select inputs. It then runs the clear cases and the interrupt sequences as short, ordered scripts, each starting after a clear pulse.

// File: rtl/io_port_pkg.sv
package io_port_pkg;

  // Control terms derived from the mode and select inputs
  typedef struct packed {
    logic selected;   // both selects at their active level
    logic load;       // transparent-latch enable
    logic drive;      // output enable
  } port_ctrl_t;

  // Active levels of the two select pins
  localparam bit SEL_N_ACTIVE = 1'b0;
  localparam bit SEL_ACTIVE   = 1'b1;

endpackage

// File: rtl/port_select_decode.sv
module port_select_decode
  import io_port_pkg::*;
(
  input  logic       sel_n,
  input  logic       sel,
  input  logic       mode,
  input  logic       strobe,
  output port_ctrl_t ctrl
);

  logic hit;

  always_comb begin
    hit = (sel_n == SEL_N_ACTIVE) && (sel == SEL_ACTIVE);
    ctrl.selected = hit;
    // output mode: select term loads, drivers always on
    // input mode : strobe loads, drivers follow select
    ctrl.load  = mode ? hit  : strobe;
    ctrl.drive = mode ? 1'b1 : hit;
  end

endmodule

// File: rtl/port_data_latch.sv
module port_data_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH-1:0] held;

  // load has priority over clear, as a high latch clock overrides clear
  always_ff @(posedge clk) begin
    if (load)        held <= din;
    else if (!clr_n) held <= ZERO;
  end

  // transparent bypass; clear reaches the output without an edge
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      assign dout[b] = load ? din[b] : (clr_n & held[b]);
    end
  endgenerate

  // R5: without load and clear the held byte stays put
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!clr_n)
    (!load && clr_n) |=> $stable(held));

  // R7: a load edge during clear still captures the input
  a_r7_load_beats_clear: assert property (@(posedge clk)
    (load && !clr_n) |=> (held == $past(din)));

endmodule

// File: rtl/port_service_req.sv
module port_service_req (
  input  logic clk,
  input  logic clr_n,
  input  logic strobe,
  input  logic selected,
  output logic req
);

  logic strobe_q;
  logic strobe_fall;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  assign strobe_fall = strobe_q & ~strobe;

  // selection wins over a coincident strobe fall
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)           req <= 1'b0;
    else if (selected)    req <= 1'b0;
    else if (strobe_fall) req <= 1'b1;
  end

  // R8: an observed strobe fall while unselected raises the request
  a_r8_fall_sets_req: assert property (@(posedge clk) disable iff (!clr_n)
    (strobe_q && !strobe && !selected) |=> req);

  // R9: selection at an edge leaves the request clear
  a_r9_select_clears_req: assert property (@(posedge clk) disable iff (!clr_n)
    selected |=> !req);

  // R8: a request only appears after a fall
  a_r8_no_spurious_req: assert property (@(posedge clk) disable iff (!clr_n)
    (!req && !(strobe_q && !strobe)) |=> !req);

endmodule

// File: rtl/strobed_io_port.sv
module strobed_io_port #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             sel_n,
  input  logic             sel,
  input  logic             mode,
  input  logic             strobe,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             oe,
  output logic             irq_n
);
  import io_port_pkg::*;

  port_ctrl_t ctrl;
  logic       req;

  port_select_decode u_decode (
    .sel_n  (sel_n),
    .sel    (sel),
    .mode   (mode),
    .strobe (strobe),
    .ctrl   (ctrl)
  );

  port_data_latch #(.WIDTH(WIDTH)) u_latch (
    .clk   (clk),
    .clr_n (clr_n),
    .load  (ctrl.load),
    .din   (din),
    .dout  (dout)
  );

  port_service_req u_req (
    .clk      (clk),
    .clr_n    (clr_n),
    .strobe   (strobe),
    .selected (ctrl.selected),
    .req      (req)
  );

  assign oe    = ctrl.drive;
  assign irq_n = ~(req | ctrl.selected);

  // R2: output mode always drives
  a_r2_output_mode_drives: assert property (@(posedge clk)
    mode |-> oe);

  // R3 / R1: input mode drives only with both selects active
  a_r3_input_mode_drive: assert property (@(posedge clk)
    !mode |-> (oe == (!sel_n && sel)));

  // R4: transparent path while loading
  a_r4_pass_through: assert property (@(posedge clk)
    ctrl.load |-> (dout == din));

  // R6: clear without load zeroes the output
  a_r6_clear_zeroes: assert property (@(posedge clk)
    (!clr_n && !ctrl.load) |-> (dout == '0));

  // R11: pending request pulls the interrupt low
  a_r11_req_irq: assert property (@(posedge clk)
    req |-> !irq_n);

  // R10: clear leaves no pending request
  a_r10_clear_no_req: assert property (@(posedge clk)
    !clr_n |-> !req);

endmodule

// File: tb/test_strobed_io_port.sv
module test_strobed_io_port;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 8;

  logic             clk = 1'b0;
  logic             clr_n = 1'b0;
  logic             sel_n = 1'b1;
  logic             sel = 1'b0;
  logic             mode = 1'b0;
  logic             strobe = 1'b0;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] dout;
  logic             oe;
  logic             irq_n;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobed_io_port #(.WIDTH(WIDTH)) i_strobed_io_port (
    .clk(clk), .clr_n(clr_n), .sel_n(sel_n), .sel(sel), .mode(mode),
    .strobe(strobe), .din(din), .dout(dout), .oe(oe), .irq_n(irq_n)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive_edge();
    @(negedge clk);
  endtask

  // store a byte through output mode with the port selected
  task automatic load_byte(input logic [WIDTH-1:0] v);
    @(negedge clk); mode = 1'b1; sel_n = 1'b0; sel = 1'b1; strobe = 1'b0; din = v;
    @(negedge clk); sel = 1'b0; sel_n = 1'b1;
  endtask

  task automatic clear_pulse();
    @(negedge clk); clr_n = 1'b0;
    @(negedge clk); clr_n = 1'b1;
  endtask

  initial begin
    // reset state
    sel_n = 1'b1; sel = 1'b0; mode = 1'b0; strobe = 1'b0; din = 8'h00;
    @(negedge clk); @(negedge clk);
    #1;
    check("R10 reset irq_n", irq_n, 1);
    check("R3 reset oe", oe, 0);
    clr_n = 1'b1;
    @(negedge clk); mode = 1'b1; #1;
    check("R6 reset dout", dout, 0);

    // sweep all mode/strobe/select combinations
    for (int c = 0; c < 16; c++) begin
      logic m, s, sn, sa, hit, ld, en;
      logic [WIDTH-1:0] l_val, d_val;
      m = c[3]; s = c[2]; sn = c[1]; sa = c[0];
      l_val = 8'(8'h11 * (c + 1) ^ 8'h5A);
      d_val = 8'(~l_val + 8'(c));
      hit = !sn && sa;
      ld = m ? hit : s;
      en = m | hit;
      load_byte(l_val);
      @(negedge clk); mode = m; strobe = s; sel_n = sn; sel = sa; din = d_val;
      #1;
      check($sformatf("R1 R2 R3 oe combo %0d", c), oe, en);
      if (en) check($sformatf("R4 R5 dout combo %0d", c), dout, ld ? d_val : l_val);
      @(negedge clk); mode = 1'b1; sel_n = 1'b1; sel = 1'b0; strobe = 1'b0; din = 8'hFF;
      #1;
      check($sformatf("R5 stored combo %0d", c), dout, ld ? d_val : l_val);
    end

    // R6: clear with load term low
    load_byte(8'hA5);
    @(negedge clk); #1;
    check("R5 hold A5", dout, 8'hA5);
    clr_n = 1'b0; #1;
    check("R6 async zero", dout, 0);
    @(negedge clk); clr_n = 1'b1; #1;
    check("R6 zero after clear", dout, 0);

    // R7: clear while strobe high in input mode
    @(negedge clk); mode = 1'b0; sel_n = 1'b0; sel = 1'b1; strobe = 1'b1; din = 8'h3C; clr_n = 1'b0;
    #1;
    check("R7 pass during clear", dout, 8'h3C);
    @(negedge clk); clr_n = 1'b1; strobe = 1'b0; sel_n = 1'b1; sel = 1'b0; mode = 1'b1; din = 8'h00;
    #1;
    check("R7 captured during clear", dout, 8'h3C);

    // interrupt sequence: strobe -> select -> cleared
    mode = 1'b0;
    clear_pulse(); #1;
    check("R11 idle irq_n", irq_n, 1);
    @(negedge clk); strobe = 1'b1;
    @(negedge clk); strobe = 1'b0; #1;
    check("R8 not yet set", irq_n, 1);
    @(negedge clk); #1;
    check("R8 request set", irq_n, 0);
    @(negedge clk); @(negedge clk); #1;
    check("R8 request held", irq_n, 0);
    sel_n = 1'b0; sel = 1'b1; #1;
    check("R11 selected irq_n", irq_n, 0);
    @(negedge clk); sel_n = 1'b1; sel = 1'b0; #1;
    check("R9 cleared by select", irq_n, 1);

    // R9: coincident fall and select
    @(negedge clk); strobe = 1'b1;
    @(negedge clk); strobe = 1'b0; sel_n = 1'b0; sel = 1'b1;
    @(negedge clk); sel_n = 1'b1; sel = 1'b0; #1;
    check("R9 select wins", irq_n, 1);
    @(negedge clk); #1;
    check("R9 stays clear", irq_n, 1);

    // R10: asynchronous clear of pending request
    @(negedge clk); strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    @(negedge clk); #1;
    check("R8 set again", irq_n, 0);
    #1 clr_n = 1'b0; #1;
    check("R10 async clear", irq_n, 1);
    @(negedge clk); clr_n = 1'b1;
    @(negedge clk); #1;
    check("R10 no request after clear", irq_n, 1);

    // R11: selection alone, with select lines partly active
    sel_n = 1'b0; sel = 1'b0; #1;
    check("R1 half select irq_n", irq_n, 1);
    sel = 1'b1; #1;
    check("R11 select only irq_n", irq_n, 0);
    @(negedge clk); sel_n = 1'b1; sel = 1'b0; #1;
    check("R11 deselect irq_n", irq_n, 1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule